// File: doc/BRIEF.md
# Global Interrupt Controller

This block gathers 127 level-sensitive interrupt lines for a single hart context. Each line is latched into a pending bit by its own gateway. Each source also carries a 3-bit priority and an enable bit. The block compares the strongest enabled pending source against a threshold and raises the external-interrupt request when that source is strong enough. Software uses a simple 32-bit register bus to set priorities, enables and the threshold. It reads the claim/complete register to learn which source to service, and writes the same register to finish servicing it.

A claim returns the winning ID and clears that source's pending bit in the same operation. The source then stays blocked until a completion names it, so a line that stays high is reported only once per service cycle. Reads return data in the cycle after the request. Writes take effect at the clock edge that samples them.

Register map (byte offsets; only aligned 32-bit accesses): priority of ID n at 4·n (0x000 to 0x1FC); pending words at 0x400 + 4·w; enable words at 0x800 + 4·w; threshold at 0xC00; claim/complete at 0xC04.

Top module: `eic_top`

## Requirements
- R1: After reset, every priority, enable, pending bit and the threshold are 0, `irq_o` is low and a claim read returns 0.
- R2: Input line k (0-based) is source ID k+1. Pending and enable bits for ID n sit in bit n mod 32 of word n/32. Bit 0 of word 0 (ID 0) and bits for IDs above the source count always read 0, even after a write of all ones.
- R3: The priority register at offset 4·n keeps the low 3 bits of a write and reads back zero-extended. The register for ID 0 reads 0. A source of priority 0 never raises `irq_o` and is never returned by a claim.
- R4: Among enabled pending sources, the highest priority wins. When priorities are equal, the lowest ID wins.
- R5: `irq_o` is high exactly when the winning source's priority is strictly greater than the threshold. A threshold of 7 holds `irq_o` low.
- R6: A read of claim/complete returns the winning ID, or 0 if there is none, whatever the threshold is. The same read clears that source's pending bit.
- R7: A claimed source is not set pending again while its line stays high. After a completion naming it, it is set pending again if its line is high.
- R8: A completion write whose ID names a source that is not enabled at that moment has no effect. The ID is not compared with the last claim.
- R9: A line that is high for one cycle sets its pending bit, and the bit stays set after the line falls until a claim clears it.
- R10: An access with address bits [1:0] not zero is ignored: a write changes nothing and a read returns 0.
- R11: The pending words are read-only: writes to them leave the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Interrupt lines, active high; bit k is ID k+1 |
| bus_req_i | input | 1 | Register access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | External-interrupt request to the hart |

## Verification
On every cycle, the assertions check these points: no candidate outranks the arbitration winner, ties resolve to the lower ID, and a claim clears the pending bit and blocks the source. They also check that a blocked source stays clear, that a latched bit survives until it is claimed, that the claim data matches the winner, that a threshold of 7 mutes the request, and that misaligned writes change nothing. The bench scenarios cover the rest: the bit packing of the words, priority readback for every ID, the full priority-by-threshold grid, and completions that are dropped while the source is disabled. They also show that a source is pended again after its completion and that a pulse stays latched after the line falls.

// File: rtl/eic_pkg.sv
package eic_pkg;

    // Address region, taken from the two top address bits
    typedef enum logic [1:0] {
        RGN_PRIO = 2'd0,
        RGN_PEND = 2'd1,
        RGN_EN   = 2'd2,
        RGN_CTRL = 2'd3
    } rgn_e;

    // Word index inside the control region
    localparam int CTRL_THR   = 0;
    localparam int CTRL_CLAIM = 1;

endpackage

// File: rtl/eic_gateway_bank.sv
module eic_gateway_bank #(
    parameter int NUM_SRC = 127,
    parameter int ID_W    = 7
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               claim_go_i,
    input  logic [ID_W-1:0]    claim_id_i,
    input  logic               done_go_i,
    input  logic [ID_W-1:0]    done_id_i,
    output logic [NUM_SRC:0]   pend_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] busy;
    } gw_t;

    gw_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (claim_go_i && claim_id_i == ID_W'(k + 1)) begin
                s_d.pend[k] = 1'b0;
                s_d.busy[k] = 1'b1;
            end else begin
                s_d.pend[k] = s_q.pend[k] | (src_i[k] & ~s_q.busy[k]);
                if (done_go_i && done_id_i == ID_W'(k + 1)) begin
                    s_d.busy[k] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pend_o = {s_q.pend, 1'b0};

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
        // R6: a claim clears the bit and blocks the source
        p_claim_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (claim_go_i && claim_id_i == ID_W'(k + 1)) |=> (!s_q.pend[k] && s_q.busy[k]));
        // R7: a blocked source without completion stays clear
        p_busy_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (s_q.busy[k] && !(done_go_i && done_id_i == ID_W'(k + 1))) |=> !s_q.pend[k]);
        // R9: a latched bit persists until claimed
        p_latched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (s_q.pend[k] && !(claim_go_i && claim_id_i == ID_W'(k + 1))) |=> s_q.pend[k]);
    end

endmodule

// File: rtl/eic_arbiter.sv
module eic_arbiter #(
    parameter int N_ID   = 128,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 7
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [N_ID-1:0]              cand_i,
    input  logic [N_ID-1:0][PRIO_W-1:0]  prio_i,
    output logic [ID_W-1:0]              best_id_o,
    output logic [PRIO_W-1:0]            best_prio_o
);

    // Strictly-greater scan from low IDs: equal priority keeps the lower ID,
    // and priority 0 can never replace the empty result.
    always_comb begin
        best_id_o   = '0;
        best_prio_o = '0;
        for (int i = 1; i < N_ID; i++) begin
            if (cand_i[i] && prio_i[i] > best_prio_o) begin
                best_id_o   = ID_W'(i);
                best_prio_o = prio_i[i];
            end
        end
    end

    p_zero_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (best_id_o != '0) |-> (best_prio_o != '0));

    for (genvar i = 1; i < N_ID; i++) begin : g_chk
        // R4: nothing enabled and pending outranks the winner
        p_no_stronger_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cand_i[i] |-> (prio_i[i] <= best_prio_o));
        // R4: ties go to the lower ID
        p_tie_low_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cand_i[i] && prio_i[i] != '0 && prio_i[i] == best_prio_o) |-> (best_id_o <= ID_W'(i)));
    end

endmodule

// File: rtl/eic_top.sv
module eic_top
    import eic_pkg::*;
#(
    parameter int NUM_SRC = 127,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_req_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               irq_o
);

    localparam int N_ID  = NUM_SRC + 1;
    localparam int ID_W  = $clog2(N_ID);
    localparam int WORDS = (N_ID + 31) / 32;
    localparam int PADW  = WORDS * 32;
    localparam int IX_W  = ADDR_W - 4;

    typedef struct packed {
        logic [N_ID-1:0][PRIO_W-1:0] prio;
        logic [N_ID-1:0]             en;
        logic [PRIO_W-1:0]           thr;
        logic [31:0]                 rdata;
    } regs_t;

    regs_t s_d, s_q;

    logic [N_ID-1:0]   pend;
    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_prio;
    logic              claim_go, done_go;
    logic [ID_W-1:0]   done_id;
    logic              aligned;
    rgn_e              rgn;
    logic [IX_W-1:0]   idx;
    logic [PADW-1:0]   pend_pad, en_pad, en_wr;
    logic              en_hit;

    assign aligned  = (bus_addr_i[1:0] == 2'b00);
    assign rgn      = rgn_e'(bus_addr_i[ADDR_W-1 -: 2]);
    assign idx      = bus_addr_i[ADDR_W-3:2];
    assign pend_pad = PADW'(pend);
    assign en_pad   = PADW'(s_q.en);

    always_comb begin
        s_d     = s_q;
        claim_go = 1'b0;
        done_go  = 1'b0;
        done_id  = ID_W'(bus_wdata_i);
        en_wr    = en_pad;
        en_hit   = 1'b0;
        for (int i = 1; i < N_ID; i++) begin
            if (bus_wdata_i == 32'(i)) en_hit = s_q.en[i];
        end

        if (bus_req_i && bus_we_i && aligned) begin
            unique case (rgn)
                RGN_PRIO: begin
                    for (int i = 1; i < N_ID; i++) begin
                        if (idx == IX_W'(i)) s_d.prio[i] = bus_wdata_i[PRIO_W-1:0];
                    end
                end
                RGN_EN: begin
                    for (int w = 0; w < WORDS; w++) begin
                        if (idx == IX_W'(w)) en_wr[w*32 +: 32] = bus_wdata_i;
                    end
                    s_d.en    = en_wr[N_ID-1:0];
                    s_d.en[0] = 1'b0;
                end
                RGN_CTRL: begin
                    if (idx == IX_W'(CTRL_THR)) s_d.thr = bus_wdata_i[PRIO_W-1:0];
                    if (idx == IX_W'(CTRL_CLAIM)) done_go = en_hit;
                end
                default: ; // pending words are read-only
            endcase
        end

        if (bus_req_i && !bus_we_i) begin
            s_d.rdata = '0;
            if (aligned) begin
                unique case (rgn)
                    RGN_PRIO: begin
                        for (int i = 1; i < N_ID; i++) begin
                            if (idx == IX_W'(i)) s_d.rdata = 32'(s_q.prio[i]);
                        end
                    end
                    RGN_PEND: begin
                        for (int w = 0; w < WORDS; w++) begin
                            if (idx == IX_W'(w)) s_d.rdata = pend_pad[w*32 +: 32];
                        end
                    end
                    RGN_EN: begin
                        for (int w = 0; w < WORDS; w++) begin
                            if (idx == IX_W'(w)) s_d.rdata = en_pad[w*32 +: 32];
                        end
                    end
                    default: begin
                        if (idx == IX_W'(CTRL_THR)) s_d.rdata = 32'(s_q.thr);
                        if (idx == IX_W'(CTRL_CLAIM)) begin
                            s_d.rdata = 32'(best_id);
                            claim_go  = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    eic_gateway_bank #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) u_gw (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_i),
        .claim_go_i (claim_go),
        .claim_id_i (best_id),
        .done_go_i  (done_go),
        .done_id_i  (done_id),
        .pend_o     (pend)
    );

    eic_arbiter #(
        .N_ID   (N_ID),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
    ) u_arb (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cand_i      (pend & s_q.en),
        .prio_i      (s_q.prio),
        .best_id_o   (best_id),
        .best_prio_o (best_prio)
    );

    assign irq_o       = (best_prio > s_q.thr);
    assign bus_rdata_o = s_q.rdata;

    // R6: claim data is the winner seen when the read was sampled
    p_claim_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim_go |=> (bus_rdata_o == 32'($past(best_id))));
    // R5: the top threshold mutes the request
    p_thr_max_mutes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.thr == {PRIO_W{1'b1}}) |-> !irq_o);
    // R10: misaligned writes leave the registers alone
    p_misalign_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && bus_we_i && !aligned) |=> ($stable(s_q.thr) && $stable(s_q.en) && $stable(s_q.prio)));

endmodule

// File: tb/eic_top_tb.sv
module eic_top_tb;

    localparam int NSRC = 40;
    localparam logic [11:0] A_THR = 12'hC00;
    localparam logic [11:0] A_CLM = 12'hC04;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            req = 1'b0;
    logic            we = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    eic_top #(.NUM_SRC(NSRC), .PRIO_W(3), .ADDR_W(12)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    function automatic logic [11:0] a_prio(int id); return 12'(id * 4); endfunction
    function automatic logic [11:0] a_pend(int w);  return 12'(32'h400 + w * 4); endfunction
    function automatic logic [11:0] a_en(int w);    return 12'(32'h800 + w * 4); endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rdr(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();

        // R1: reset state
        chk("R1 irq", 32'(irq), 0);
        rdr(A_CLM, rd);   chk("R1 claim", rd, 0);
        rdr(A_THR, rd);   chk("R1 threshold", rd, 0);
        rdr(a_prio(5), rd); chk("R1 priority", rd, 0);
        rdr(a_pend(0), rd); chk("R1 pending", rd, 0);
        rdr(a_en(1), rd);   chk("R1 enable", rd, 0);

        // R3: priority readback sweep, low 3 bits kept, ID 0 reads 0
        for (int id = 0; id <= NSRC; id++) wr(a_prio(id), 32'hFFFF_FFF8 | 32'(id % 8));
        for (int id = 0; id <= NSRC; id++) begin
            rdr(a_prio(id), rd);
            chk("R3 priority readback", rd, (id == 0) ? 0 : 32'(id % 8));
        end

        // R2: line to ID mapping and bit packing
        do_reset();
        @(negedge clk); src[0] = 1'b1; src[NSRC-1] = 1'b1;
        @(negedge clk);
        rdr(a_pend(0), rd); chk("R2 pending word0", rd, 32'h2);
        rdr(a_pend(1), rd); chk("R2 pending word1", rd, 32'h1 << (NSRC - 32));
        wr(a_en(0), 32'hFFFF_FFFF); rdr(a_en(0), rd); chk("R2 enable ID0 hardwired", rd, 32'hFFFF_FFFE);
        wr(a_en(1), 32'hFFFF_FFFF); rdr(a_en(1), rd); chk("R2 enable upper IDs absent", rd, 32'h1FF);
        // R11: pending words ignore writes
        wr(a_pend(0), 32'h0);       rdr(a_pend(0), rd); chk("R11 pending read-only", rd, 32'h2);
        wr(a_pend(1), 32'hFFFF_FFFF); rdr(a_pend(1), rd); chk("R11 pending read-only", rd, 32'h100);
        // R10: misaligned accesses
        wr(A_THR, 32'd5);
        wr(A_THR + 12'd1, 32'd2); rdr(A_THR, rd); chk("R10 misaligned write", rd, 5);
        rdr(A_THR + 12'd2, rd);   chk("R10 misaligned read", rd, 0);

        // R4: priority order and lowest-ID ties
        do_reset();
        wr(a_en(0), 32'hFFFF_FFFF); wr(a_en(1), 32'hFFFF_FFFF);
        wr(a_prio(3), 2); wr(a_prio(7), 5); wr(a_prio(9), 5); wr(a_prio(35), 4);
        @(negedge clk); src[2] = 1; src[6] = 1; src[8] = 1; src[34] = 1;
        @(negedge clk);
        chk("R5 irq with threshold 0", 32'(irq), 1);
        rdr(A_CLM, rd); chk("R4 tie lowest ID", rd, 7);
        rdr(A_CLM, rd); chk("R4 second of tie", rd, 9);
        rdr(A_CLM, rd); chk("R4 next priority", rd, 35);
        rdr(A_CLM, rd); chk("R4 lowest priority", rd, 3);
        rdr(A_CLM, rd); chk("R6 empty claim", rd, 0);
        chk("R7 all blocked irq", 32'(irq), 0);
        // R8: completion not compared with last claim
        wr(A_CLM, 9); rdr(a_pend(0), rd); chk("R8 any claimed ID completes", rd, 32'h200);

        // R5: priority x threshold grid
        do_reset();
        wr(a_en(0), 32'hFFFF_FFFF);
        @(negedge clk); src[11] = 1'b1;
        for (int p = 0; p < 8; p++) begin
            wr(a_prio(12), 32'(p));
            for (int t = 0; t < 8; t++) begin
                wr(A_THR, 32'(t));
                chk($sformatf("R5 irq p=%0d t=%0d", p, t), 32'(irq), (p > t) ? 1 : 0);
            end
        end
        // R3: priority 0 is never claimed
        wr(a_prio(12), 0); rdr(A_CLM, rd); chk("R3 priority 0 not claimed", rd, 0);
        // R6: claim ignores threshold (threshold is 7 here)
        wr(a_prio(12), 6); rdr(A_CLM, rd); chk("R6 claim ignores threshold", rd, 12);
        // R7: line still high, source stays clear until completion
        repeat (5) @(negedge clk);
        rdr(a_pend(0), rd); chk("R7 no re-pend while claimed", rd, 0);
        wr(A_CLM, 12); rdr(a_pend(0), rd); chk("R7 re-pend after completion", rd, 32'h1000);
        // R8: completion for a disabled source is dropped
        rdr(A_CLM, rd); chk("R6 claim again", rd, 12);
        wr(a_en(0), 0); wr(A_CLM, 12); wr(a_en(0), 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        rdr(a_pend(0), rd); chk("R8 disabled completion ignored", rd, 0);
        wr(A_CLM, 12); rdr(a_pend(0), rd); chk("R8 enabled completion accepted", rd, 32'h1000);

        // R9: one-cycle pulse stays latched
        do_reset();
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk); src[4] = 1'b0;
        repeat (3) @(negedge clk);
        rdr(a_pend(0), rd); chk("R9 pulse latched", rd, 32'h20);
        wr(a_en(0), 32'hFFFF_FFFF); wr(a_prio(5), 1);
        rdr(A_CLM, rd); chk("R9 latched pulse claimed", rd, 5);
        rdr(a_pend(0), rd); chk("R6 claim clears pending", rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule